// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block runs the hardware side of taking an exception or an external interrupt on a small 32-bit core with 16-bit instructions. In its idle state it looks at a pending synchronous exception and a pending interrupt request. It picks one of them, or turns the exception into a reset request when the core is blocked. It then saves the context and computes the handler address. The core keeps the requesting inputs valid for one cycle and holds off new requests until the sequence ends. The block takes its own copy of the status word, PC, stack register, vector base and delay-slot flag on that cycle, so the core may change them afterwards.

The sequence is a five-state machine. **IDLE** has four ways out: to **SAVE** when an exception is accepted, to **QUERY** when an interrupt is accepted, to **BLOCKED** when an exception arrives while blocked, or back to itself when nothing is accepted. **QUERY** asks the interrupt controller for a vector under the current mask. From QUERY the machine goes to SAVE when a vector is returned, or back to IDLE when none is. **SAVE** writes the saved status, saved PC and saved stack register and always moves to **VECTOR**. **VECTOR** writes the new status word, the event code and the new PC, pulses `entry_done` and goes back to IDLE. **BLOCKED** pulses `reset_req` and goes back to IDLE.

Status word bits used: BL block bit 28, RB bank bit 29, MD privileged bit 30, FD FPU-disable bit 15, interrupt mask bits 7:4.

Top module: `exc_entry_seq`

## Requirements
- R1: When `exc_valid` and an acceptable `irq_pending` are both present on the same idle cycle, the exception is taken. `ivec_req` stays low, `expevt_out` gets the exception code and `intevt_out` keeps its value.
- R2: When SR bit 28 is set and an exception with a code other than 0x1E0 arrives, `reset_req` pulses high for exactly one cycle, visible after the second rising edge that counts the sampling edge. No entry takes place and `entry_done` stays low. Code 0x1E0 with bit 28 set is entered normally.
- R3: While SR bit 28 is set, an interrupt is accepted only when `in_sleep` is high. Otherwise it is ignored and all outputs keep their values.
- R4: An interrupt that arrives while `delay_slot` is high is not accepted (`ivec_req` stays low) and all outputs keep their values.
- R5: For an accepted interrupt, `ivec_req` is high for one cycle with `ivec_mask` equal to SR[7:4]. If `ivec_valid` is low in that cycle, nothing is entered and all outputs keep their values.
- R6: On every entry, `ssr_out` takes the sampled SR and `sgr_out` takes the sampled R15. `sr_out` is the sampled SR with bits 28, 29 and 30 set.
- R7: For an exception taken with `delay_slot` high, `spc_out` is the sampled PC minus 2, and `ds_clear` pulses together with `entry_done`. Otherwise `spc_out` is the sampled PC and `ds_clear` stays low.
- R8: Codes 0x000 and 0x020 additionally clear SR bit 15, set SR[7:4] to 0xF and load `pc_out` with 0xA0000000.
- R9: Codes 0x040 and 0x060 set `pc_out` to VBR+0x400. Every other non-reset exception code sets it to VBR+0x100. Every exception writes its code to `expevt_out`.
- R10: An interrupt entry sets `pc_out` to VBR+0x600 and writes the returned vector to `intevt_out`. `expevt_out` keeps its value.
- R11: For the trap code 0x160, `spc_out` is advanced by 2 on top of the R7 rule. A trap in a delay slot therefore saves the PC unchanged.
- R12: After reset all outputs are zero. For an exception, `entry_done` is a one-cycle pulse visible after the third rising edge that counts the sampling edge. For an interrupt it is visible after the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_valid | input | 1 | Synchronous exception pending |
| exc_code | input | 12 | Exception event code |
| irq_pending | input | 1 | External interrupt pending |
| in_sleep | input | 1 | Core is in its sleep state |
| delay_slot | input | 1 | Current instruction sits in a branch delay slot |
| sr_in | input | 32 | Current status word |
| pc_in | input | 32 | Current PC |
| r15_in | input | 32 | Current stack register |
| vbr_in | input | 32 | Vector base |
| ivec_req | output | 1 | Vector request to the interrupt controller |
| ivec_mask | output | 4 | Interrupt mask sent with the request |
| ivec_valid | input | 1 | Controller returns a vector this cycle |
| ivec_code | input | 12 | Returned interrupt vector code |
| entry_done | output | 1 | One-cycle pulse: handler entry complete |
| reset_req | output | 1 | One-cycle pulse: system reset request |
| ds_clear | output | 1 | One-cycle pulse: core clears its delay-slot flag |
| sr_out | output | 32 | New status word |
| ssr_out | output | 32 | Saved status word |
| spc_out | output | 32 | Saved PC |
| sgr_out | output | 32 | Saved stack register |
| expevt_out | output | 12 | Last exception event code |
| intevt_out | output | 12 | Last interrupt event code |
| pc_out | output | 32 | Handler PC |

## Verification
Edges are counted from the sampling edge, which counts as one. `reset_req` is due after the second edge, an exception's `entry_done` after the third, and an interrupt's `entry_done` after the fourth because of the extra QUERY cycle. The driver stamps each expected item with that due cycle. The monitor checks on the falling edge that every pulse arrives in exactly the stamped cycle. Stimuli that must be ignored push no item, so any pulse they cause shows up as unexpected. After those stimuli the bench also reads the outputs back to confirm they have not moved.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int CODE_W      = 12;
    localparam int SR_BL_BIT   = 28;
    localparam int SR_RB_BIT   = 29;
    localparam int SR_MD_BIT   = 30;
    localparam int SR_FD_BIT   = 15;
    localparam int SR_IMASK_LO = 4;
    localparam int IMASK_W     = 4;

    localparam logic [CODE_W-1:0] CODE_PWR_RESET = 12'h000;
    localparam logic [CODE_W-1:0] CODE_MAN_RESET = 12'h020;
    localparam logic [CODE_W-1:0] CODE_TLB_RD    = 12'h040;
    localparam logic [CODE_W-1:0] CODE_TLB_WR    = 12'h060;
    localparam logic [CODE_W-1:0] CODE_TRAP      = 12'h160;
    localparam logic [CODE_W-1:0] CODE_BL_EXEMPT = 12'h1E0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUERY,
        ST_SAVE,
        ST_VECTOR,
        ST_BLOCKED
    } seq_state_e;

    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_EXC,
        REQ_IRQ,
        REQ_BLOCKED
    } req_kind_e;

    typedef enum logic [1:0] {
        VC_RESET,
        VC_TLB,
        VC_GENERAL,
        VC_IRQ
    } vec_class_e;

    function automatic vec_class_e class_of(input logic [CODE_W-1:0] code,
                                            input logic is_irq);
        if (is_irq)
            return VC_IRQ;
        else if (code == CODE_PWR_RESET || code == CODE_MAN_RESET)
            return VC_RESET;
        else if (code == CODE_TLB_RD || code == CODE_TLB_WR)
            return VC_TLB;
        else
            return VC_GENERAL;
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_seq_pkg::*;
(
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_pending,
    input  logic              sr_blocked,
    input  logic              in_sleep,
    input  logic              delay_slot,
    output req_kind_e         kind
);

    logic irq_ok;

    always_comb begin
        irq_ok = irq_pending && !delay_slot && (!sr_blocked || in_sleep);
        if (exc_valid) begin
            if (sr_blocked && exc_code != CODE_BL_EXEMPT)
                kind = REQ_BLOCKED;
            else
                kind = REQ_EXC;
        end else if (irq_ok) begin
            kind = REQ_IRQ;
        end else begin
            kind = REQ_NONE;
        end
    end

endmodule

// File: rtl/exc_target_calc.sv
module exc_target_calc
    import exc_seq_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              INSN_BYTES = 2,
    parameter logic [XLEN-1:0] OFS_TLB    = 32'h0000_0400,
    parameter logic [XLEN-1:0] OFS_GEN    = 32'h0000_0100,
    parameter logic [XLEN-1:0] OFS_IRQ    = 32'h0000_0600,
    parameter logic [XLEN-1:0] RESET_PC   = 32'hA000_0000
)(
    input  logic              is_irq,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   sr,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   vbr,
    input  logic              in_ds,
    output logic [XLEN-1:0]   new_sr,
    output logic [XLEN-1:0]   new_pc,
    output logic [XLEN-1:0]   saved_pc
);

    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    vec_class_e      vclass;
    logic [XLEN-1:0] back_step;
    logic [XLEN-1:0] fwd_step;

    always_comb begin
        vclass = class_of(code, is_irq);

        new_sr = sr;
        new_sr[SR_BL_BIT] = 1'b1;
        new_sr[SR_RB_BIT] = 1'b1;
        new_sr[SR_MD_BIT] = 1'b1;
        if (vclass == VC_RESET) begin
            new_sr[SR_FD_BIT] = 1'b0;
            new_sr[SR_IMASK_LO +: IMASK_W] = '1;
        end

        unique case (vclass)
            VC_RESET:   new_pc = RESET_PC;
            VC_TLB:     new_pc = vbr + OFS_TLB;
            VC_GENERAL: new_pc = vbr + OFS_GEN;
            VC_IRQ:     new_pc = vbr + OFS_IRQ;
            default:    new_pc = vbr + OFS_GEN;
        endcase

        back_step = in_ds ? STEP : '0;
        fwd_step  = (!is_irq && code == CODE_TRAP) ? STEP : '0;
        saved_pc  = pc - back_step + fwd_step;
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              INSN_BYTES = 2,
    parameter logic [XLEN-1:0] OFS_TLB    = 32'h0000_0400,
    parameter logic [XLEN-1:0] OFS_GEN    = 32'h0000_0100,
    parameter logic [XLEN-1:0] OFS_IRQ    = 32'h0000_0600,
    parameter logic [XLEN-1:0] RESET_PC   = 32'hA000_0000
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_pending,
    input  logic              in_sleep,
    input  logic              delay_slot,
    input  logic [XLEN-1:0]   sr_in,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   r15_in,
    input  logic [XLEN-1:0]   vbr_in,
    output logic              ivec_req,
    output logic [IMASK_W-1:0] ivec_mask,
    input  logic              ivec_valid,
    input  logic [CODE_W-1:0] ivec_code,
    output logic              entry_done,
    output logic              reset_req,
    output logic              ds_clear,
    output logic [XLEN-1:0]   sr_out,
    output logic [XLEN-1:0]   ssr_out,
    output logic [XLEN-1:0]   spc_out,
    output logic [XLEN-1:0]   sgr_out,
    output logic [CODE_W-1:0] expevt_out,
    output logic [CODE_W-1:0] intevt_out,
    output logic [XLEN-1:0]   pc_out
);

    seq_state_e        state_q, state_d;
    req_kind_e         kind;

    logic              is_irq_q;
    logic [CODE_W-1:0] code_q;
    logic [XLEN-1:0]   sr_q, pc_q, r15_q, vbr_q;
    logic              ds_q;

    logic [XLEN-1:0]   calc_sr, calc_pc, calc_spc;

    exc_arbiter u_arb (
        .exc_valid   (exc_valid),
        .exc_code    (exc_code),
        .irq_pending (irq_pending),
        .sr_blocked  (sr_in[SR_BL_BIT]),
        .in_sleep    (in_sleep),
        .delay_slot  (delay_slot),
        .kind        (kind)
    );

    exc_target_calc #(
        .XLEN       (XLEN),
        .INSN_BYTES (INSN_BYTES),
        .OFS_TLB    (OFS_TLB),
        .OFS_GEN    (OFS_GEN),
        .OFS_IRQ    (OFS_IRQ),
        .RESET_PC   (RESET_PC)
    ) u_calc (
        .is_irq   (is_irq_q),
        .code     (code_q),
        .sr       (sr_q),
        .pc       (pc_q),
        .vbr      (vbr_q),
        .in_ds    (ds_q),
        .new_sr   (calc_sr),
        .new_pc   (calc_pc),
        .saved_pc (calc_spc)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                unique case (kind)
                    REQ_EXC:     state_d = ST_SAVE;
                    REQ_IRQ:     state_d = ST_QUERY;
                    REQ_BLOCKED: state_d = ST_BLOCKED;
                    default:     state_d = ST_IDLE;
                endcase
            end
            ST_QUERY:   state_d = ivec_valid ? ST_SAVE : ST_IDLE;
            ST_SAVE:    state_d = ST_VECTOR;
            ST_VECTOR:  state_d = ST_IDLE;
            ST_BLOCKED: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // sampled context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_irq_q <= 1'b0;
            code_q   <= '0;
            sr_q     <= '0;
            pc_q     <= '0;
            r15_q    <= '0;
            vbr_q    <= '0;
            ds_q     <= 1'b0;
        end else if (state_q == ST_IDLE && kind != REQ_NONE) begin
            is_irq_q <= (kind == REQ_IRQ);
            code_q   <= exc_code;
            sr_q     <= sr_in;
            pc_q     <= pc_in;
            r15_q    <= r15_in;
            vbr_q    <= vbr_in;
            ds_q     <= delay_slot && (kind != REQ_IRQ);
        end else if (state_q == ST_QUERY && ivec_valid) begin
            code_q   <= ivec_code;
        end
    end

    assign ivec_req  = (state_q == ST_QUERY);
    assign ivec_mask = sr_q[SR_IMASK_LO +: IMASK_W];

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_done <= 1'b0;
            reset_req  <= 1'b0;
            ds_clear   <= 1'b0;
            sr_out     <= '0;
            ssr_out    <= '0;
            spc_out    <= '0;
            sgr_out    <= '0;
            expevt_out <= '0;
            intevt_out <= '0;
            pc_out     <= '0;
        end else begin
            entry_done <= 1'b0;
            reset_req  <= 1'b0;
            ds_clear   <= 1'b0;
            unique case (state_q)
                ST_SAVE: begin
                    ssr_out <= sr_q;
                    sgr_out <= r15_q;
                    spc_out <= calc_spc;
                end
                ST_VECTOR: begin
                    sr_out     <= calc_sr;
                    pc_out     <= calc_pc;
                    entry_done <= 1'b1;
                    ds_clear   <= ds_q;
                    if (is_irq_q) intevt_out <= code_q;
                    else          expevt_out <= code_q;
                end
                ST_BLOCKED: reset_req <= 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       exc_valid,
    input logic       irq_pending,
    input logic       delay_slot,
    input logic       entry_done,
    input logic       reset_req,
    input logic       ivec_req,
    input logic [2:0] mode_bits,
    input logic       st_idle
);

    // R1
    exc_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_idle && exc_valid |=> !ivec_req);

    // R4
    ds_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_idle && !exc_valid && irq_pending && delay_slot |=> !ivec_req);

    // R5
    query_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ivec_req) |-> $past(irq_pending));

    // R2
    reset_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> !entry_done);

    // R2
    reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    // R6
    mode_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> (mode_bits == 3'b111));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |=> !entry_done);

endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_valid   (exc_valid),
    .irq_pending (irq_pending),
    .delay_slot  (delay_slot),
    .entry_done  (entry_done),
    .reset_req   (reset_req),
    .ivec_req    (ivec_req),
    .mode_bits   (sr_out[30:28]),
    .st_idle     (state_q == exc_seq_pkg::ST_IDLE)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid = 1'b0;
    logic [11:0] exc_code = '0;
    logic        irq_pending = 1'b0;
    logic        in_sleep = 1'b0;
    logic        delay_slot = 1'b0;
    logic [31:0] sr_in = '0, pc_in = '0, r15_in = '0, vbr_in = '0;
    logic        ivec_req;
    logic [3:0]  ivec_mask;
    logic        ivec_valid;
    logic [11:0] ivec_code;
    logic        entry_done, reset_req, ds_clear;
    logic [31:0] sr_out, ssr_out, spc_out, sgr_out, pc_out;
    logic [11:0] expevt_out, intevt_out;

    logic        ctl_has = 1'b0;
    logic [11:0] ctl_code = '0;

    always #4 clk = ~clk;

    assign ivec_valid = ivec_req & ctl_has;
    assign ivec_code  = ctl_code;

    exc_entry_seq u_exc_entry_seq (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
        .irq_pending(irq_pending), .in_sleep(in_sleep), .delay_slot(delay_slot),
        .sr_in(sr_in), .pc_in(pc_in), .r15_in(r15_in), .vbr_in(vbr_in),
        .ivec_req(ivec_req), .ivec_mask(ivec_mask), .ivec_valid(ivec_valid),
        .ivec_code(ivec_code), .entry_done(entry_done), .reset_req(reset_req),
        .ds_clear(ds_clear), .sr_out(sr_out), .ssr_out(ssr_out),
        .spc_out(spc_out), .sgr_out(sgr_out), .expevt_out(expevt_out),
        .intevt_out(intevt_out), .pc_out(pc_out)
    );

    typedef struct {
        string       tag;
        bit          is_rst;
        int          due;
        logic [31:0] sr, ssr, spc, sgr, pc;
        logic [11:0] expevt, intevt;
        bit          dsc;
    } exp_t;

    exp_t sb[$];
    exp_t cur;

    int   cyc = 0;
    int   ncheck = 0;
    int   nbad = 0;
    bit   saw_req = 1'b0;
    logic [3:0] seen_mask = '0;

    logic [31:0] m_pc = '0;
    logic [11:0] m_expevt = '0, m_intevt = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        ncheck++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && ivec_req) begin
            saw_req   = 1'b1;
            seen_mask = ivec_mask;
        end
        if (rst_n && (entry_done || reset_req)) begin
            if (sb.size() == 0) begin
                chk("R12", "unexpected pulse", {30'd0, reset_req, entry_done}, 32'd0);
            end else begin
                cur = sb.pop_front();
                chk("R12", "due cycle", cyc, cur.due);
                if (cur.is_rst) begin
                    chk(cur.tag, "reset_req", reset_req, 1);
                    chk(cur.tag, "entry_done during reset", entry_done, 0);
                end else begin
                    chk(cur.tag, "entry_done", entry_done, 1);
                    chk("R6", "sr_out", sr_out, cur.sr);
                    chk("R6", "ssr_out", ssr_out, cur.ssr);
                    chk("R6", "sgr_out", sgr_out, cur.sgr);
                    chk(cur.tag, "spc_out", spc_out, cur.spc);
                    chk(cur.tag, "pc_out", pc_out, cur.pc);
                    chk(cur.tag, "expevt_out", expevt_out, cur.expevt);
                    chk(cur.tag, "intevt_out", intevt_out, cur.intevt);
                    chk("R7", "ds_clear", ds_clear, cur.dsc);
                end
            end
        end
    end

    // driver: computes expectations from the requirements and pushes them
    task automatic fire(input string tag, input bit ev, input logic [11:0] code,
                        input bit irq, input logic [31:0] sr, input logic [31:0] pc,
                        input logic [31:0] r15, input logic [31:0] vbr,
                        input bit ds, input bit sleep, input bit has_vec,
                        input logic [11:0] vec);
        exp_t e;
        int   s;
        bit   blocked_exc, irq_ok, is_reset, entry;
        blocked_exc = ev && sr[28] && code != 12'h1E0;
        irq_ok      = irq && !ev && !ds && (!sr[28] || sleep);
        is_reset    = ev && (code == 12'h000 || code == 12'h020);
        entry       = (ev && !blocked_exc) || (irq_ok && has_vec);
        saw_req     = 1'b0;

        e.tag = tag; e.is_rst = blocked_exc;
        e.ssr = sr; e.sgr = r15;
        e.sr  = sr | 32'h7000_0000;
        if (is_reset) begin
            e.sr[15] = 1'b0;
            e.sr[7:4] = 4'hF;
        end
        if (ev) begin
            e.spc = pc - (ds ? 32'd2 : 32'd0) + (code == 12'h160 ? 32'd2 : 32'd0);
            e.pc  = is_reset ? 32'hA000_0000 :
                    (code == 12'h040 || code == 12'h060) ? vbr + 32'h400 : vbr + 32'h100;
            e.expevt = code; e.intevt = m_intevt; e.dsc = ds;
        end else begin
            e.spc = pc; e.pc = vbr + 32'h600;
            e.expevt = m_expevt; e.intevt = vec; e.dsc = 1'b0;
        end

        @(negedge clk);
        exc_valid = ev; exc_code = code; irq_pending = irq;
        sr_in = sr; pc_in = pc; r15_in = r15; vbr_in = vbr;
        delay_slot = ds; in_sleep = sleep; ctl_has = has_vec; ctl_code = vec;
        @(posedge clk);
        #1 s = cyc;
        if (blocked_exc) begin
            e.due = s + 1;
            sb.push_back(e);
        end else if (entry) begin
            e.due = ev ? s + 2 : s + 3;
            sb.push_back(e);
            m_pc = e.pc; m_expevt = e.expevt; m_intevt = e.intevt;
        end
        @(negedge clk);
        exc_valid = 1'b0; irq_pending = 1'b0;
        sr_in = 32'hDEAD_BEEF; pc_in = 32'h1234_5678; delay_slot = 1'b0;
        repeat (6) @(negedge clk);
        chk(tag, "vector request seen", saw_req, irq_ok);
        if (irq_ok) chk("R5", "ivec_mask", seen_mask, sr[7:4]);
        chk(tag, "pc_out after sequence", pc_out, m_pc);
        chk(tag, "expevt_out after sequence", expevt_out, m_expevt);
        chk(tag, "items left", sb.size(), 0);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12", "reset entry_done", entry_done, 0);
        chk("R12", "reset reset_req", reset_req, 0);
        chk("R12", "reset ivec_req", ivec_req, 0);
        chk("R12", "reset pc_out", pc_out, 0);
        chk("R12", "reset sr_out", sr_out, 0);

        fire("R9",  1, 12'h0E0, 0, 32'h0000_0030, 32'h8C00_1000, 32'h8C0F_FF00, 32'h8C00_0000, 0, 0, 0, 0);
        fire("R9",  1, 12'h040, 0, 32'h0000_00F0, 32'h0040_2000, 32'h7000_0010, 32'h8C00_0000, 0, 0, 0, 0);
        fire("R9",  1, 12'h060, 0, 32'h4000_0000, 32'h0040_2004, 32'h1111_2222, 32'h9000_0000, 0, 0, 0, 0);
        fire("R11", 1, 12'h160, 0, 32'h0000_0000, 32'h0000_3000, 32'h0000_4000, 32'h8000_0000, 0, 0, 0, 0);
        fire("R7",  1, 12'h180, 0, 32'h0000_8010, 32'h0000_5002, 32'h0000_6000, 32'h8000_0000, 1, 0, 0, 0);
        fire("R11", 1, 12'h160, 0, 32'h0000_0000, 32'h0000_7006, 32'h0000_8000, 32'h8000_0000, 1, 0, 0, 0);
        fire("R8",  1, 12'h000, 0, 32'h0000_8030, 32'h0000_9000, 32'h0000_A000, 32'h8000_0000, 0, 0, 0, 0);
        fire("R8",  1, 12'h020, 0, 32'h4000_8050, 32'h0000_9100, 32'h0000_A100, 32'h8100_0000, 0, 0, 0, 0);
        fire("R2",  1, 12'h0E0, 0, 32'h1000_0000, 32'h0000_B000, 32'h0000_C000, 32'h8000_0000, 0, 0, 0, 0);
        fire("R2",  1, 12'h1E0, 0, 32'h1000_0000, 32'h0000_B100, 32'h0000_C100, 32'h8200_0000, 0, 0, 0, 0);
        fire("R10", 0, 12'h000, 1, 32'h0000_0050, 32'h0000_D000, 32'h0000_E000, 32'h8C00_0000, 0, 0, 1, 12'h320);
        fire("R1",  1, 12'h0A0, 1, 32'h0000_0020, 32'h0000_D100, 32'h0000_E100, 32'h8C00_0000, 0, 0, 1, 12'h340);
        fire("R3",  0, 12'h000, 1, 32'h1000_0070, 32'h0000_D200, 32'h0000_E200, 32'h8C00_0000, 0, 0, 1, 12'h360);
        fire("R3",  0, 12'h000, 1, 32'h1000_00A0, 32'h0000_D300, 32'h0000_E300, 32'h8D00_0000, 0, 1, 1, 12'h400);
        fire("R4",  0, 12'h000, 1, 32'h0000_0010, 32'h0000_D400, 32'h0000_E400, 32'h8C00_0000, 1, 0, 1, 12'h380);
        fire("R5",  0, 12'h000, 1, 32'h0000_00C0, 32'h0000_D500, 32'h0000_E500, 32'h8C00_0000, 0, 0, 0, 12'h3A0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", ncheck, nbad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            ncheck++;
            nbad++;
            $display("FAIL R12 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", ncheck, nbad);
            $finish;
        end
    end

endmodule